// File: doc/BRIEF.md
# Flag Offset Loader

This block holds the four threshold offsets used by the status logic of a pair of FIFOs: an almost-full and an almost-empty offset for each FIFO. Once per master reset it picks how those offsets are filled. It can load one of five fixed values into all four at once. It can take four words written on a wide data port. It can also take a single serial bit stream clocked in one bit per cycle. When the chosen method has finished, the block raises a done flag.

The three select inputs are read during master reset. The last clock edge that sees master reset low fixes the method and the preset value. After that, two of the select pins change role and act as the serial enable (active low) and the serial data input. A partial reset only pauses loading. It leaves the method, the offsets already loaded and the done flag untouched. The FIFO storage and the flag comparators are outside this block and simply read the four offset outputs.

Top module: `offset_loader`

## Requirements
- R1: The method is taken from `{cfgSel2, cfgSelEnN, cfgSelData}` on the last rising clock edge with `mrstN` low. The code map is: 000 serial; 001 preset 8; 010 preset 16; 011 preset 64; 100 preset 256; 101 preset 1024; 110 and 111 parallel. Changes on the select pins after release do not change the method until the next master reset.
- R2: On any rising edge with `mrstN` low, all four offsets are cleared to 0 and `loadDone` is cleared to 0.
- R3: In preset mode, the first rising edge with `mrstN` and `prstN` both high loads the preset value into all four offsets and sets `loadDone`.
- R4: In serial mode, each rising edge with `cfgSelEnN` low shifts `cfgSelData` into the offset chain. An edge with `cfgSelEnN` high leaves the offsets unchanged.
- R5: The serial chain is 4×OFS_W bits long and is filled MSB first, in this order: `afOfsA`, `aeOfsA`, `afOfsB`, `aeOfsB`. The first bit shifted in ends at the MSB of `afOfsA`, and the last bit ends at the LSB of `aeOfsB`.
- R6: `loadDone` rises on the edge that takes the 4×OFS_W-th serial bit. From then on, serial bits change nothing until the next master reset.
- R7: In parallel mode, each edge with `parWrEn` high loads `parData[OFS_W-1:0]` into the next offset, in the order `afOfsA`, `aeOfsA`, `afOfsB`, `aeOfsB`; the upper data bits are ignored. `loadDone` rises on the fourth write, and later writes change nothing.
- R8: While `prstN` is low and `mrstN` is high, no loading takes place. The method, the four offsets and `loadDone` all keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrstN | input | 1 | Master reset, active low, synchronous |
| prstN | input | 1 | Partial reset, active low; pauses loading |
| cfgSelData | input | 1 | Select bit 0; serial data once serial mode is chosen |
| cfgSelEnN | input | 1 | Select bit 1; serial enable (active low) once serial mode is chosen |
| cfgSel2 | input | 1 | Select bit 2 |
| parWrEn | input | 1 | Parallel offset write strobe |
| parData | input | DATA_W | Parallel offset data; low OFS_W bits used |
| afOfsA | output | OFS_W | Almost-full offset, FIFO A |
| aeOfsA | output | OFS_W | Almost-empty offset, FIFO A |
| afOfsB | output | OFS_W | Almost-full offset, FIFO B |
| aeOfsB | output | OFS_W | Almost-empty offset, FIFO B |
| loadDone | output | 1 | Offsets complete for the chosen method |

## Verification
The bench builds the block with its defaults: OFS_W of 15, four offsets and a 36-bit data port. That makes the serial chain 60 bits long, the length a 32K-deep pair needs. At this size a full serial load, including random enable gaps and a partial-reset pause in the middle of the stream, takes a few hundred cycles. The bench can therefore repeat random streams and random parallel words several times and still drive every preset code. The 36-bit port carries random upper bits, so the ignored field above the 15-bit offset is exercised on every parallel write.

// File: rtl/offset_loader_pkg.sv
package offset_loader_pkg;

  typedef enum logic [1:0] {
    MODE_PRESET   = 2'd0,
    MODE_PARALLEL = 2'd1,
    MODE_SERIAL   = 2'd2
  } loadMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic loadPreset;
    logic shiftBit;
    logic shiftWord;
    logic serBit;
  } dpStrobe_t;

  localparam int PRESET_W = 11;

  function automatic loadMode_e decodeMode(input logic [2:0] sel);
    case (sel)
      3'b000:         decodeMode = MODE_SERIAL;
      3'b110, 3'b111: decodeMode = MODE_PARALLEL;
      default:        decodeMode = MODE_PRESET;
    endcase
  endfunction

  function automatic logic [PRESET_W-1:0] presetFor(input logic [2:0] sel);
    case (sel)
      3'b001:  presetFor = PRESET_W'(8);
      3'b010:  presetFor = PRESET_W'(16);
      3'b011:  presetFor = PRESET_W'(64);
      3'b100:  presetFor = PRESET_W'(256);
      3'b101:  presetFor = PRESET_W'(1024);
      default: presetFor = '0;
    endcase
  endfunction

endpackage

// File: rtl/offset_loader_ctrl.sv
module offset_loader_ctrl
  import offset_loader_pkg::*;
#(
  parameter int OFS_W    = 15,
  parameter int NUM_REGS = 4
) (
  input  logic             clk,
  input  logic             mrstN,
  input  logic             prstN,
  input  logic [2:0]       sel,
  input  logic             parWrEn,
  output dpStrobe_t        stb,
  output logic [OFS_W-1:0] presetVal,
  output logic             done
);

  localparam int TOTAL_BITS = NUM_REGS * OFS_W;
  localparam int CNT_W      = $clog2(TOTAL_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(TOTAL_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(NUM_REGS - 1);

  loadMode_e        mode;
  logic [CNT_W-1:0] cnt;
  logic             active;

  assign active = mrstN && prstN && !done;

  always_comb begin
    stb        = '0;
    stb.clear  = !mrstN;
    stb.serBit = sel[0];
    if (active) begin
      case (mode)
        MODE_PRESET:   stb.loadPreset = 1'b1;
        MODE_SERIAL:   stb.shiftBit   = !sel[1];
        MODE_PARALLEL: stb.shiftWord  = parWrEn;
        default:       ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!mrstN) begin
      mode      <= decodeMode(sel);
      presetVal <= OFS_W'(presetFor(sel));
      cnt       <= '0;
      done      <= 1'b0;
    end else begin
      if (stb.loadPreset) done <= 1'b1;
      if (stb.shiftBit) begin
        cnt <= cnt + 1'b1;
        if (cnt == LAST_BIT) done <= 1'b1;
      end
      if (stb.shiftWord) begin
        cnt <= cnt + 1'b1;
        if (cnt == LAST_WORD) done <= 1'b1;
      end
    end
  end

  // R1
  mode_hold_chk: assert property (@(posedge clk) disable iff (!mrstN)
    1'b1 |=> $stable(mode));

  // R6
  done_sticky_chk: assert property (@(posedge clk) disable iff (!mrstN)
    done |=> done);

  // R8
  prst_pause_chk: assert property (@(posedge clk) disable iff (!mrstN)
    !prstN |=> ($stable(cnt) && $stable(done)));

endmodule

// File: rtl/offset_loader_dp.sv
module offset_loader_dp
  import offset_loader_pkg::*;
#(
  parameter int OFS_W    = 15,
  parameter int NUM_REGS = 4
) (
  input  logic                           clk,
  input  dpStrobe_t                      stb,
  input  logic [OFS_W-1:0]               presetVal,
  input  logic [OFS_W-1:0]               wordIn,
  output logic [NUM_REGS-1:0][OFS_W-1:0] ofs
);

  localparam int TOTAL_BITS = NUM_REGS * OFS_W;

  logic [TOTAL_BITS-1:0] chain;

  always_ff @(posedge clk) begin
    if (stb.clear)
      chain <= '0;
    else if (stb.loadPreset)
      chain <= {NUM_REGS{presetVal}};
    else if (stb.shiftBit)
      chain <= {chain[TOTAL_BITS-2:0], stb.serBit};
    else if (stb.shiftWord)
      chain <= {chain[TOTAL_BITS-OFS_W-1:0], wordIn};
  end

  // Register 0 sits at the top of the chain and is filled first
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slice
    assign ofs[i] = chain[TOTAL_BITS-1-i*OFS_W -: OFS_W];
  end

  // R4
  idle_hold_chk: assert property (@(posedge clk)
    !(stb.clear || stb.loadPreset || stb.shiftBit || stb.shiftWord) |=> $stable(chain));

  // R3
  preset_fill_chk: assert property (@(posedge clk)
    (stb.loadPreset && !stb.clear) |=> (ofs[0] == ofs[NUM_REGS-1]) && (ofs[0] == $past(presetVal)));

endmodule

// File: rtl/offset_loader.sv
module offset_loader
  import offset_loader_pkg::*;
#(
  parameter int OFS_W  = 15,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              mrstN,
  input  logic              prstN,
  input  logic              cfgSelData,
  input  logic              cfgSelEnN,
  input  logic              cfgSel2,
  input  logic              parWrEn,
  input  logic [DATA_W-1:0] parData,
  output logic [OFS_W-1:0]  afOfsA,
  output logic [OFS_W-1:0]  aeOfsA,
  output logic [OFS_W-1:0]  afOfsB,
  output logic [OFS_W-1:0]  aeOfsB,
  output logic              loadDone
);

  localparam int NUM_REGS = 4;

  dpStrobe_t                      stb;
  logic [OFS_W-1:0]               presetVal;
  logic [NUM_REGS-1:0][OFS_W-1:0] ofs;
  logic                           unusedParHigh;

  assign unusedParHigh = ^parData[DATA_W-1:OFS_W];

  offset_loader_ctrl #(.OFS_W(OFS_W), .NUM_REGS(NUM_REGS)) u_ctrl (
    .clk       (clk),
    .mrstN     (mrstN),
    .prstN     (prstN),
    .sel       ({cfgSel2, cfgSelEnN, cfgSelData}),
    .parWrEn   (parWrEn),
    .stb       (stb),
    .presetVal (presetVal),
    .done      (loadDone)
  );

  offset_loader_dp #(.OFS_W(OFS_W), .NUM_REGS(NUM_REGS)) u_dp (
    .clk       (clk),
    .stb       (stb),
    .presetVal (presetVal),
    .wordIn    (parData[OFS_W-1:0]),
    .ofs       (ofs)
  );

  assign afOfsA = ofs[0];
  assign aeOfsA = ofs[1];
  assign afOfsB = ofs[2];
  assign aeOfsB = ofs[3];

  // R2
  mrst_clear_chk: assert property (@(posedge clk)
    !mrstN |=> (!loadDone && afOfsA == '0 && aeOfsB == '0));

endmodule

// File: tb/sim_offset_loader.sv
module sim_offset_loader;

  localparam int OFS_W  = 15;
  localparam int DATA_W = 36;
  localparam int BITS   = 4 * OFS_W;

  logic              clk = 1'b0;
  logic              mrstN, prstN, cfgSelData, cfgSelEnN, cfgSel2, parWrEn;
  logic [DATA_W-1:0] parData;
  logic [OFS_W-1:0]  afOfsA, aeOfsA, afOfsB, aeOfsB;
  logic              loadDone;

  int nChecks = 0;
  int nFail   = 0;

  always #4 clk = ~clk;

  offset_loader #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .mrstN(mrstN), .prstN(prstN), .cfgSelData(cfgSelData),
    .cfgSelEnN(cfgSelEnN), .cfgSel2(cfgSel2), .parWrEn(parWrEn), .parData(parData),
    .afOfsA(afOfsA), .aeOfsA(aeOfsA), .afOfsB(afOfsB), .aeOfsB(aeOfsB),
    .loadDone(loadDone)
  );

  function automatic logic [OFS_W-1:0] expPreset(input logic [2:0] code);
    case (code)
      3'b001:  return OFS_W'(8);
      3'b010:  return OFS_W'(16);
      3'b011:  return OFS_W'(64);
      3'b100:  return OFS_W'(256);
      3'b101:  return OFS_W'(1024);
      default: return '0;
    endcase
  endfunction

  function automatic logic [BITS-1:0] allOfs();
    return {afOfsA, aeOfsA, afOfsB, aeOfsB};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  // Master reset with a select code; the pins are then moved to an idle value
  task automatic resetWith(input logic [2:0] code);
    @(negedge clk);
    mrstN = 1'b0; prstN = 1'b1; parWrEn = 1'b0;
    {cfgSel2, cfgSelEnN, cfgSelData} = code;
    repeat (2) @(negedge clk);
    chk("R2 offsets cleared", 64'(allOfs()), 64'd0);
    chk("R2 done cleared", 64'(loadDone), 64'd0);
    mrstN = 1'b1; cfgSel2 = 1'b0; cfgSelEnN = 1'b1; cfgSelData = 1'b0;
  endtask

  task automatic serialFeed(input logic [BITS-1:0] v, input int from, input int upto,
                            input bit gaps);
    for (int i = from; i < upto; i++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        @(negedge clk); cfgSelEnN = 1'b1; cfgSelData = ~v[BITS-1-i];
      end
      @(negedge clk); cfgSelEnN = 1'b0; cfgSelData = v[BITS-1-i];
    end
    @(negedge clk); cfgSelEnN = 1'b1;
  endtask

  task automatic parWrite(input logic [DATA_W-1:0] w);
    if ($urandom % 2 == 0) @(negedge clk);
    @(negedge clk); parWrEn = 1'b1; parData = w;
    @(negedge clk); parWrEn = 1'b0; parData = {DATA_W{1'b1}};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [BITS-1:0] v, snap;
    logic [DATA_W-1:0] w [4];
    void'($urandom(32'd2718));
    mrstN = 1'b0; prstN = 1'b1; cfgSelData = 1'b0; cfgSelEnN = 1'b0; cfgSel2 = 1'b0;
    parWrEn = 1'b0; parData = '0;

    // R3: every preset code; pins change to code 010 after release (R1)
    for (int c = 1; c <= 5; c++) begin
      resetWith(3'(c));
      @(negedge clk);
      chk("R3 preset afOfsA", 64'(afOfsA), 64'(expPreset(3'(c))));
      chk("R3 preset aeOfsB", 64'(aeOfsB), 64'(expPreset(3'(c))));
      chk("R3 preset all", 64'(allOfs()), 64'({4{expPreset(3'(c))}}));
      chk("R3 done", 64'(loadDone), 64'd1);
    end

    // R1: after release in preset mode, serial-looking activity changes nothing
    repeat (5) begin
      @(negedge clk); cfgSelEnN = 1'b0; cfgSelData = 1'($urandom);
    end
    @(negedge clk); cfgSelEnN = 1'b1;
    chk("R1 preset mode kept", 64'(allOfs()), 64'({4{expPreset(3'd5)}}));

    // R8: partial reset before a preset load defers it
    resetWith(3'b011);
    prstN = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 preset deferred", 64'(loadDone), 64'd0);
    prstN = 1'b1;
    @(negedge clk);
    chk("R8 preset after pause", 64'(allOfs()), 64'({4{expPreset(3'b011)}}));

    // Serial streams with random gaps
    for (int t = 0; t < 3; t++) begin
      v = {$urandom, $urandom};
      resetWith(3'b000);
      serialFeed(v, 0, 30, 1'b1);
      chk("R6 not done midway", 64'(loadDone), 64'd0);
      chk("R4 partial shift", 64'(allOfs()), 64'(v[BITS-1:30]));
      snap = allOfs();
      // R4: enable high, data toggling
      repeat (4) begin
        @(negedge clk); cfgSelEnN = 1'b1; cfgSelData = 1'($urandom);
      end
      @(negedge clk);
      chk("R4 enable high holds", 64'(allOfs()), 64'(snap));
      // R8: partial reset with enable low
      prstN = 1'b0; cfgSelEnN = 1'b0; cfgSelData = 1'b1;
      repeat (3) @(negedge clk);
      chk("R8 partial reset holds", 64'(allOfs()), 64'(snap));
      prstN = 1'b1; cfgSelEnN = 1'b1;
      serialFeed(v, 30, BITS - 1, t[0]);
      chk("R6 not done at 59", 64'(loadDone), 64'd0);
      serialFeed(v, BITS - 1, BITS, 1'b0);
      chk("R5 afOfsA", 64'(afOfsA), 64'(v[59:45]));
      chk("R5 aeOfsA", 64'(aeOfsA), 64'(v[44:30]));
      chk("R5 afOfsB", 64'(afOfsB), 64'(v[29:15]));
      chk("R5 aeOfsB", 64'(aeOfsB), 64'(v[14:0]));
      chk("R6 done after last bit", 64'(loadDone), 64'd1);
      serialFeed(~v, 0, 10, 1'b0);
      chk("R6 extra bits ignored", 64'(allOfs()), 64'(v));
    end

    // Directed serial corner: single 1 as first bit lands at MSB of afOfsA
    resetWith(3'b000);
    serialFeed({1'b1, {(BITS-1){1'b0}}}, 0, BITS, 1'b0);
    chk("R5 first bit at top", 64'(afOfsA), 64'(1 << (OFS_W - 1)));
    chk("R5 rest zero", 64'(aeOfsB), 64'd0);

    // Parallel loads with random upper bits
    for (int t = 0; t < 3; t++) begin
      resetWith(t[0] ? 3'b111 : 3'b110);
      for (int k = 0; k < 4; k++) w[k] = {$urandom, $urandom};
      parWrite(w[0]);
      parWrite(w[1]);
      @(negedge clk);
      chk("R7 not done after two", 64'(loadDone), 64'd0);
      parWrite(w[2]);
      parWrite(w[3]);
      @(negedge clk);
      chk("R7 afOfsA", 64'(afOfsA), 64'(w[0][OFS_W-1:0]));
      chk("R7 aeOfsA", 64'(aeOfsA), 64'(w[1][OFS_W-1:0]));
      chk("R7 afOfsB", 64'(afOfsB), 64'(w[2][OFS_W-1:0]));
      chk("R7 aeOfsB", 64'(aeOfsB), 64'(w[3][OFS_W-1:0]));
      chk("R7 done", 64'(loadDone), 64'd1);
      parWrite({$urandom, $urandom});
      @(negedge clk);
      chk("R7 extra write ignored", 64'(afOfsA), 64'(w[0][OFS_W-1:0]));
      // R8: partial reset after done keeps everything
      prstN = 1'b0;
      repeat (2) @(negedge clk);
      prstN = 1'b1;
      @(negedge clk);
      chk("R8 values kept", 64'(aeOfsB), 64'(w[3][OFS_W-1:0]));
      chk("R8 done kept", 64'(loadDone), 64'd1);
    end

    resetWith(3'b010);
    summary();
    $finish;
  end

endmodule